// File: doc/BRIEF.md
# GPIO Pin State Resolver

This block works out, once per clock, the effective electrical state of a bank of general-purpose pins. Each pin has a configuration word, a bit from the output latch, and an external stimulus made of a level and a flag that says whether anything drives the pin from outside. From these the block decides whether the pin drives its output and at what level. It also decides what the sampled input bit should hold and whether the internal and external drivers fight.

The configuration word selects the direction, a pull resistor, whether the input buffer is cut off, and a drive mode that can restrict the pin to driving only high or only low levels. A pull on a floating pin makes the pin behave as though driven at the pull level. A change strobe tells downstream logic, such as a pin model or an event tracker, that the driven state or driven level has moved since the previous evaluation.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The drive mode sits in configuration bits 10:8. Modes 0 to 3 let the pin drive at either level. Modes 4 and 5 let it drive only while its output latch bit is 1. Modes 6 and 7 let it drive only while the latch bit is 0.
- R2: A pin drives only when configuration bit 0 (direction) is 1 and the drive mode allows it. The one exception is the pull case of R5.
- R3: Configuration bits 3:2 encode the pull. Code 1 is pull-down (level 0) and code 3 is pull-up (level 1). Codes 0 and 2 mean no pull.
- R4: When configuration bit 1 is 1, the input buffer is disconnected. With a pull active, the sampled input takes the pull level whatever the external stimulus is. With no pull, the sampled input takes the external level while one is driven and otherwise holds its value.
- R5: With the input buffer connected and no external driver, a pull on a pin that is not driving makes the pin drive at the pull level. Whenever the pin drives in this case, the sampled input takes the driven level. With an external driver present, the sampled input takes the external level.
- R6: short_err for a pin is 1 when the input buffer is connected, the pin drives, an external driver is present and the two levels differ. Otherwise it is 0.
- R7: chg_strobe for a pin pulses for one cycle when the drive state or the drive level differs from the one stored at the previous evaluation. The drive level is the latch bit, or the pull level in the R5 case. No pulse is produced when neither changed.
- R8: When the external stimulus is undriven (ext_valid 0) and nothing else sets the input, the sampled input holds its previous value.
- R9: A pin that does not drive shows pin_oe 0 and pin_out 0. A pin that drives shows pin_oe 1 and its level on pin_out.
- R10: All results are registered and appear one clock after the inputs that cause them. Reset clears every output and the stored previous state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_cfg | input | NPINS*CFG_W | Configuration words; pin i uses bits [i*CFG_W +: CFG_W] |
| out_latch | input | NPINS | Output latch bit per pin |
| ext_level | input | NPINS | External level per pin |
| ext_valid | input | NPINS | 1 when an external driver is present on the pin |
| in_sample | output | NPINS | Sampled input bit per pin |
| pin_out | output | NPINS | Driven level per pin, 0 when not driving |
| pin_oe | output | NPINS | Output enable per pin |
| chg_strobe | output | NPINS | One-cycle pulse on a change of drive state or level |
| short_err | output | NPINS | Conflict between internal and external drive |

## Verification
Every result is due in the cycle after the stimulus that causes it. The bench therefore changes inputs on the falling edge, lets exactly one rising edge pass, and samples shortly after that edge. The change strobe is checked at two points: after the first edge it must be high, and after a second edge with the inputs held it must be low again. The vector table chains rows so that later rows check input values held from earlier ones, and its expected levels follow only from the requirement rules.

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver #(
  parameter int NPINS = 32,
  parameter int CFG_W = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS*CFG_W-1:0] pin_cfg,
  input  logic [NPINS-1:0]       out_latch,
  input  logic [NPINS-1:0]       ext_level,
  input  logic [NPINS-1:0]       ext_valid,
  output logic [NPINS-1:0]       in_sample,
  output logic [NPINS-1:0]       pin_out,
  output logic [NPINS-1:0]       pin_oe,
  output logic [NPINS-1:0]       chg_strobe,
  output logic [NPINS-1:0]       short_err
);

  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] in_nx, oe_nx, lvl_nx, sc_nx;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [CFG_W-1:0] c;
    logic [2:0]       mode;
    logic             pull_en, pull_lv, mode_ok, drv, cur;

    assign c       = pin_cfg[g*CFG_W +: CFG_W];
    assign mode    = c[10:8];
    assign pull_en = c[2];
    assign pull_lv = c[3];
    assign mode_ok = !mode[2] || (mode[1] ? !out_latch[g] : out_latch[g]);
    assign drv     = mode_ok && c[0];
    assign cur     = ext_valid[g] ? ext_level[g] : in_sample[g];

    always_comb begin
      oe_nx[g]  = drv;
      lvl_nx[g] = out_latch[g];
      in_nx[g]  = cur;
      sc_nx[g]  = 1'b0;
      if (c[1]) begin
        if (pull_en) in_nx[g] = pull_lv;
      end else begin
        sc_nx[g] = drv && ext_valid[g] && (out_latch[g] != ext_level[g]);
        if (!ext_valid[g]) begin
          if (pull_en && !drv) begin
            oe_nx[g]  = 1'b1;
            lvl_nx[g] = pull_lv;
          end
          if (oe_nx[g]) in_nx[g] = lvl_nx[g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sample  <= '0;
      pin_oe     <= '0;
      lvl_q      <= '0;
      chg_strobe <= '0;
      short_err  <= '0;
    end else begin
      in_sample  <= in_nx;
      pin_oe     <= oe_nx;
      lvl_q      <= lvl_nx;
      chg_strobe <= (oe_nx ^ pin_oe) | (lvl_nx ^ lvl_q);
      short_err  <= sc_nx;
    end
  end

  assign pin_out = pin_oe & lvl_q;

endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk #(
  parameter int NPINS = 32,
  parameter int CFG_W = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPINS*CFG_W-1:0] pin_cfg,
  input logic [NPINS-1:0]       out_latch,
  input logic [NPINS-1:0]       ext_level,
  input logic [NPINS-1:0]       ext_valid,
  input logic [NPINS-1:0]       in_sample,
  input logic [NPINS-1:0]       pin_out,
  input logic [NPINS-1:0]       pin_oe,
  input logic [NPINS-1:0]       chg_strobe,
  input logic [NPINS-1:0]       short_err
);

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    logic [CFG_W-1:0] c;
    assign c = pin_cfg[g*CFG_W +: CFG_W];

    p_high_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (c[0] && c[10:8] inside {3'd4, 3'd5} && !out_latch[g] && !c[2]) |=> !pin_oe[g]);

    p_low_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (c[0] && c[10:8] inside {3'd6, 3'd7} && out_latch[g] && !c[2]) |=> !pin_oe[g]);

    p_dir_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!c[0] && (c[1] || ext_valid[g] || !c[2])) |=> !pin_oe[g]);

    p_disc_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (c[1] && c[2]) |=> (in_sample[g] == $past(c[3])));

    p_ext_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!c[1] && ext_valid[g]) |=> (in_sample[g] == $past(ext_level[g])));

    p_short_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      short_err[g] |-> $past(ext_valid[g] && !c[1] && c[0]));

    p_strobe_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe[g] != $past(pin_oe[g])) |-> chg_strobe[g]);

    p_hold_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!c[1] && !ext_valid[g] && !c[0] && !c[2]) |=> $stable(in_sample[g]));
  end

endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NPINS(NPINS), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_cfg(pin_cfg), .out_latch(out_latch),
  .ext_level(ext_level), .ext_valid(ext_valid), .in_sample(in_sample),
  .pin_out(pin_out), .pin_oe(pin_oe), .chg_strobe(chg_strobe), .short_err(short_err)
);

// File: tb/sim_gpio_pin_resolver.sv
module sim_gpio_pin_resolver;
  localparam int NPINS = 32;
  localparam int CFG_W = 11;
  localparam int P = 5;
  localparam int NV = 17;

  // row: {cfg[10:0], out, ext_valid, ext_level, exp_in, exp_oe, exp_out, exp_short}
  localparam logic [17:0] VEC [NV] = '{
    {11'h001, 3'b100, 4'b1110},
    {11'h001, 3'b110, 4'b0111},
    {11'h401, 3'b000, 4'b0000},
    {11'h401, 3'b100, 4'b1110},
    {11'h601, 3'b100, 4'b1000},
    {11'h601, 3'b000, 4'b0100},
    {11'h00C, 3'b100, 4'b1110},
    {11'h004, 3'b111, 4'b1000},
    {11'h004, 3'b000, 4'b0100},
    {11'h00E, 3'b010, 4'b1000},
    {11'h002, 3'b011, 4'b1000},
    {11'h002, 3'b000, 4'b1000},
    {11'h003, 3'b110, 4'b0110},
    {11'h008, 3'b000, 4'b0000},
    {11'h301, 3'b000, 4'b0100},
    {11'h501, 3'b011, 4'b1000},
    {11'h701, 3'b011, 4'b1101}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic [NPINS*CFG_W-1:0] pin_cfg;
  logic [NPINS-1:0] out_latch, ext_level, ext_valid;
  logic [NPINS-1:0] in_sample, pin_out, pin_oe, chg_strobe, short_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_pin_resolver #(.NPINS(NPINS), .CFG_W(CFG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_cfg(pin_cfg), .out_latch(out_latch),
    .ext_level(ext_level), .ext_valid(ext_valid), .in_sample(in_sample),
    .pin_out(pin_out), .pin_oe(pin_oe), .chg_strobe(chg_strobe), .short_err(short_err)
  );

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic set_pin(input logic [10:0] c, input logic o, input logic ev, input logic el);
    pin_cfg[P*CFG_W +: CFG_W] = c;
    out_latch[P] = o;
    ext_valid[P] = ev;
    ext_level[P] = el;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < NPINS; i++) pin_cfg[i*CFG_W +: CFG_W] = 11'h002;
    out_latch = '0;
    ext_level = '0;
    ext_valid = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset in_sample", in_sample, 0);
    check("R10 reset pin_oe", pin_oe, 0);
    check("R10 reset chg_strobe", chg_strobe, 0);
    @(negedge clk);
    rst_n = 1;
    step();
    check("R10 idle pin_oe", pin_oe, 0);
    check("R10 idle short_err", short_err, 0);
    check("R9 idle pin_out", pin_out, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      set_pin(VEC[v][17:7], VEC[v][6], VEC[v][5], VEC[v][4]);
      step();
      check($sformatf("R1 R2 R3 R4 R5 R8 row %0d in_sample", v), in_sample[P], VEC[v][3]);
      check($sformatf("R1 R2 R5 R9 row %0d pin_oe", v), pin_oe[P], VEC[v][2]);
      check($sformatf("R9 row %0d pin_out", v), pin_out[P], VEC[v][1]);
      check($sformatf("R6 row %0d short_err", v), short_err[P], VEC[v][0]);
      check($sformatf("R9 row %0d other pins oe", v), pin_oe & ~(32'd1 << P), 0);
    end

    @(negedge clk);
    set_pin(11'h001, 1'b0, 1'b0, 1'b0);
    step(); step();
    check("R7 settled strobe low", chg_strobe[P], 0);
    @(negedge clk);
    out_latch[P] = 1'b1;
    step();
    check("R7 level change strobe", chg_strobe[P], 1);
    check("R10 level after one edge", pin_out[P], 1);
    step();
    check("R7 strobe clears when held", chg_strobe[P], 0);
    @(negedge clk);
    pin_cfg[P*CFG_W +: CFG_W] = 11'h000;
    step();
    check("R7 drive state change strobe", chg_strobe[P], 1);
    check("R2 input direction releases", pin_oe[P], 0);
    step();
    @(negedge clk);
    ext_valid[P] = 1'b1;
    ext_level[P] = 1'b1;
    step();
    check("R7 no strobe on external change", chg_strobe[P], 0);
    check("R5 input follows external", in_sample[P], 1);
    @(negedge clk);
    ext_level[P] = 1'b0;
    step();
    check("R7 still no strobe", chg_strobe[P], 0);
    check("R5 input follows external low", in_sample[P], 0);
    @(negedge clk);
    ext_level[P] = 1'b1;
    ext_valid[P] = 1'b0;
    step();
    check("R8 undriven keeps held input", in_sample[P], 0);

    @(negedge clk);
    set_pin(11'h00E, 1'b0, 1'b1, 1'b0);
    step();
    check("R4 pull-up overrides external low", in_sample[P], 1);
    @(negedge clk);
    set_pin(11'h006, 1'b0, 1'b1, 1'b1);
    step();
    check("R4 pull-down overrides external high", in_sample[P], 0);

    @(negedge clk);
    rst_n = 0;
    step();
    check("R10 reset clears outputs", {in_sample, pin_oe, chg_strobe, short_err}, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule